// File: doc/BRIEF.md
# Configurable-Format Serial Transmitter

This block turns one parallel character into an asynchronous serial frame on a single transmit line. The caller offers a character on a valid/ready handshake. An 8-bit line control word sets the framing. It selects the character width, whether a parity bit is sent and how it is formed, the stop-bit length, a break override, and a divisor-access flag that is only passed through. Bit timing comes from an external one-cycle pulse at sixteen times the baud rate, so a division stage upstream sets the line speed.

The format fields are captured when a character is accepted and held for the whole frame. Software can therefore rewrite the control word while a frame is on the line without damaging that frame. The break bit is the exception. It acts on the line output at once and for as long as it is set, but the frame sequencer keeps its own timing underneath.

Top module: `uftx_top`

## Requirements
- R1: Out of reset, `tx_ready` is 1 and `txd` is 1 (with a zero control word). A character is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from the next cycle until the frame has finished, and then returns to 1.
- R2: A frame is a start bit of 0, then the data bits least significant first, then the parity bit if it is enabled, then the stop time at 1. Each start, data and parity bit lasts exactly 16 tick pulses, counted from the accepting edge.
- R3: Control bits [1:0] set the character width: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8 bits. Data bits above the width are neither sent nor counted in parity.
- R4: Control bit 2 at 0 gives a stop time of 16 ticks. At 1 it gives 32 ticks, except with a width code of 00, where it gives 24 ticks.
- R5: Control bit 3 at 1 inserts a parity bit. Bits [5:4] select its value: 00 makes the count of ones in data plus parity odd, 01 makes it even, 10 forces 1 and 11 forces 0.
- R6: While control bit 6 is 1, `txd` is 0 in the same cycle, whatever frame is in progress. The frame's timing continues, and the line resumes the frame's current bit when the bit clears.
- R7: Control bit 7 appears on `dl_access` and has no effect on the frame.
- R8: The format is sampled on the accepting edge. A change to control bits [5:0] during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| line_ctrl | input | 8 | Line control word |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Transmitter idle, character can be taken |
| txd | output | 1 | Serial output line |
| dl_access | output | 1 | Divisor-access flag, copied from control bit 7 |

## Verification
Two pairs of events can fall in the same cycle. In one, the break bit is raised on the cycle after a data bit's midpoint and the line is read in that same cycle. The line must be low even though the sequencer is still serialising, and once the break clears, the bit that was due must come back with the frame's end tick unchanged. In the other, the control word is rewritten to a different width and parity while a frame is running. Every later bit and the frame length are judged against the format captured at acceptance.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

    localparam int DATA_MAX = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        PAR_ODD  = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ONE  = 2'b10,
        PAR_ZERO = 2'b11
    } par_mode_e;

    typedef enum logic [1:0] {
        STOP_ONE,
        STOP_ONE_HALF,
        STOP_TWO
    } stop_mode_e;

    // Field order follows the bit positions of the control word.
    typedef struct packed {
        logic       dl_flag;
        logic       brk;
        par_mode_e  par_mode;
        logic       par_en;
        logic       stop_sel;
        logic [1:0] len_code;
    } ctrl_t;

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic [2:0]          last_idx;
        logic                par_en;
        logic                par_val;
        stop_mode_e          stop_mode;
    } frame_t;

    function automatic logic [2:0] last_index(input logic [1:0] code);
        return 3'd4 + {1'b0, code};
    endfunction

    function automatic logic [DATA_MAX-1:0] mask_data(input logic [DATA_MAX-1:0] d,
                                                      input logic [1:0] code);
        logic [DATA_MAX-1:0] m;
        for (int i = 0; i < DATA_MAX; i++) begin
            m[i] = (3'(i) <= last_index(code));
        end
        return d & m;
    endfunction

    function automatic logic parity_value(input par_mode_e mode,
                                          input logic [DATA_MAX-1:0] d);
        logic p;
        case (mode)
            PAR_ODD:  p = ~(^d);
            PAR_EVEN: p = ^d;
            PAR_ONE:  p = 1'b1;
            default:  p = 1'b0;
        endcase
        return p;
    endfunction

    function automatic stop_mode_e stop_mode_of(input logic sel, input logic [1:0] code);
        stop_mode_e s;
        if (!sel)              s = STOP_ONE;
        else if (code == 2'b00) s = STOP_ONE_HALF;
        else                   s = STOP_TWO;
        return s;
    endfunction

endpackage

// File: rtl/uftx_bit_timer.sv
module uftx_bit_timer #(
    parameter int OSR = 16,
    localparam int CW = $clog2(2 * OSR + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          seg_done
);

    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end   = (cnt_q == limit - CW'(1));
    assign seg_done = run && tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= at_end ? '0 : cnt_q + CW'(1);
        end
    end

    // R2: the tick count never passes the current segment's length
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < limit));

endmodule

// File: rtl/uftx_frame_latch.sv
module uftx_frame_latch
    import uftx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  ctrl_t               ctrl,
    input  logic [DATA_MAX-1:0] data,
    output frame_t              frame_q
);

    frame_t              frame_d;
    logic [DATA_MAX-1:0] masked;

    always_comb begin
        masked            = mask_data(data, ctrl.len_code);
        frame_d.data      = masked;
        frame_d.last_idx  = last_index(ctrl.len_code);
        frame_d.par_en    = ctrl.par_en;
        frame_d.par_val   = parity_value(ctrl.par_mode, masked);
        frame_d.stop_mode = stop_mode_of(ctrl.stop_sel, ctrl.len_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (load) begin
            frame_q <= frame_d;
        end
    end

endmodule

// File: rtl/uftx_seq.sv
module uftx_seq
    import uftx_pkg::*;
#(
    parameter int OSR = 16,
    localparam int CW = $clog2(2 * OSR + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          seg_done,
    input  frame_t        frame,
    output tx_state_e     state,
    output logic          line,
    output logic [CW-1:0] limit
);

    tx_state_e  state_q, state_d;
    logic [2:0] idx_q, idx_d;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_START;
                    idx_d   = '0;
                end
            end
            ST_START: begin
                if (seg_done) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (seg_done) begin
                    if (idx_q == frame.last_idx) begin
                        state_d = frame.par_en ? ST_PARITY : ST_STOP;
                    end else begin
                        idx_d = idx_q + 3'd1;
                    end
                end
            end
            ST_PARITY: begin
                if (seg_done) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (seg_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        case (state_q)
            ST_START:  line = 1'b0;
            ST_DATA:   line = frame.data[idx_q];
            ST_PARITY: line = frame.par_val;
            default:   line = 1'b1;
        endcase
    end

    always_comb begin
        limit = CW'(OSR);
        if (state_q == ST_STOP) begin
            case (frame.stop_mode)
                STOP_ONE_HALF: limit = CW'(OSR + OSR / 2);
                STOP_TWO:      limit = CW'(2 * OSR);
                default:       limit = CW'(OSR);
            endcase
        end
    end

    assign state = state_q;

    // R3: the data index never goes beyond the captured width
    a_r3_idx_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA) |-> (idx_q <= frame.last_idx));

    // R2: data always follows a completed start bit
    a_r2_start_to_data: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && seg_done) |=> (state_q == ST_DATA && idx_q == 3'd0));

endmodule

// File: rtl/uftx_top.sv
module uftx_top
    import uftx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic [7:0] line_ctrl,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd,
    output logic       dl_access
);

    localparam int CW = $clog2(2 * OSR + 1);

    ctrl_t         ctrl;
    frame_t        frame_q;
    tx_state_e     state;
    logic          line;
    logic [CW-1:0] limit;
    logic          seg_done;
    logic          accept;

    assign ctrl      = ctrl_t'(line_ctrl);
    assign tx_ready  = (state == ST_IDLE);
    assign accept    = tx_valid && tx_ready;
    assign txd       = ctrl.brk ? 1'b0 : line;
    assign dl_access = ctrl.dl_flag;

    uftx_frame_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .ctrl    (ctrl),
        .data    (tx_data),
        .frame_q (frame_q)
    );

    uftx_bit_timer #(.OSR(OSR)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .run      (state != ST_IDLE),
        .tick     (baud_tick),
        .limit    (limit),
        .seg_done (seg_done)
    );

    uftx_seq #(.OSR(OSR)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .seg_done (seg_done),
        .frame    (frame_q),
        .state    (state),
        .line     (line),
        .limit    (limit)
    );

    // R1: an accepted character takes the transmitter out of idle
    a_r1_accept_busy: assert property (@(posedge clk) disable iff (rst)
        accept |=> !tx_ready);

    // R8: the captured format holds while a frame runs
    a_r8_frame_hold: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |=> $stable(frame_q));

    // R4: the stop time drives the line high unless break is set
    a_r4_stop_high: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP && !line_ctrl[6]) |-> txd);

endmodule

// File: tb/uftx_top_tb.sv
module uftx_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       baud_tick;
    logic [7:0] line_ctrl;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready;
    logic       txd;
    logic       dl_access;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    uftx_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .baud_tick (baud_tick),
        .line_ctrl (line_ctrl),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .txd       (txd),
        .dl_access (dl_access)
    );

    initial begin
        baud_tick = 1'b0;
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Count tick edges, then step to the next falling edge for sampling.
    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!baud_tick);
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check("R1", "ready after accept", tx_ready, 0);
    endtask

    // Send one character and check every segment at its midpoint.
    task automatic run_frame(input string req, input logic [7:0] lcr_v, input logic [7:0] d,
                             input bit chg, input logic [7:0] lcr2, input bit brk_test);
        int nb, stop_t, nseg, half;
        logic [7:0] dm;
        logic p;
        logic seg_v[12];
        int   seg_len[12];
        nb = 5 + int'(lcr_v[1:0]);
        dm = d & 8'((9'd1 << nb) - 9'd1);
        case (lcr_v[5:4])
            2'b00:   p = ~(^dm);
            2'b01:   p = ^dm;
            2'b10:   p = 1'b1;
            default: p = 1'b0;
        endcase
        if (!lcr_v[2])              stop_t = 16;
        else if (lcr_v[1:0] == 2'b00) stop_t = 24;
        else                        stop_t = 32;
        nseg = 0;
        seg_v[nseg] = 1'b0; seg_len[nseg] = 16; nseg++;
        for (int i = 0; i < nb; i++) begin
            seg_v[nseg] = dm[i]; seg_len[nseg] = 16; nseg++;
        end
        if (lcr_v[3]) begin
            seg_v[nseg] = p; seg_len[nseg] = 16; nseg++;
        end
        seg_v[nseg] = 1'b1; seg_len[nseg] = stop_t; nseg++;

        line_ctrl = lcr_v;
        send(d);
        for (int s = 0; s < nseg; s++) begin
            half = seg_len[s] / 2;
            wait_ticks(half);
            check(req, $sformatf("segment %0d value", s), txd, seg_v[s]);
            if (chg && s == 1) line_ctrl = lcr2;
            if (brk_test && s == 2) begin
                line_ctrl[6] = 1'b1;
                #1;
                check("R6", "break forces low", txd, 0);
                wait_ticks(4);
                check("R6", "break held", txd, 0);
                line_ctrl[6] = 1'b0;
                #1;
                check("R6", "bit resumes after break", txd, seg_v[s]);
                half = half + 4;
            end
            if (s == nseg - 1) begin
                wait_ticks(seg_len[s] - half - 1);
                check(req, "ready low before last tick", tx_ready, 0);
                wait_ticks(1);
                check(req, "ready high after frame", tx_ready, 1);
                check(req, "idle line high", txd, 1);
            end else begin
                wait_ticks(seg_len[s] - half);
            end
        end
    endtask

    task automatic t_reset;
        check("R1", "reset ready", tx_ready, 1);
        check("R1", "reset txd", txd, 1);
        check("R7", "reset dl_access", dl_access, 0);
    endtask

    task automatic t_widths;
        run_frame("R3", 8'h00, 8'hF5, 1'b0, 8'h00, 1'b0);  // 5-bit, upper bits dropped
        run_frame("R3", 8'h01, 8'hEA, 1'b0, 8'h00, 1'b0);
        run_frame("R3", 8'h02, 8'h9C, 1'b0, 8'h00, 1'b0);
        run_frame("R2", 8'h03, 8'hA7, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic t_parity;
        run_frame("R5", 8'h0B, 8'h35, 1'b0, 8'h00, 1'b0);  // odd
        run_frame("R5", 8'h1B, 8'h35, 1'b0, 8'h00, 1'b0);  // even
        run_frame("R5", 8'h2A, 8'h00, 1'b0, 8'h00, 1'b0);  // forced one
        run_frame("R5", 8'h3B, 8'hFF, 1'b0, 8'h00, 1'b0);  // forced zero
        run_frame("R5", 8'h08, 8'hE1, 1'b0, 8'h00, 1'b0);  // odd, 5-bit, masked bits
    endtask

    task automatic t_stops;
        run_frame("R4", 8'h04, 8'h15, 1'b0, 8'h00, 1'b0);  // 1.5 stop
        run_frame("R4", 8'h07, 8'h5A, 1'b0, 8'h00, 1'b0);  // 2 stop
        run_frame("R4", 8'h1E, 8'h33, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic t_break;
        run_frame("R6", 8'h03, 8'hFF, 1'b0, 8'h00, 1'b1);
    endtask

    task automatic t_dl_flag;
        line_ctrl = 8'h80;
        #1;
        check("R7", "dl_access set", dl_access, 1);
        run_frame("R7", 8'h8B, 8'h6C, 1'b0, 8'h00, 1'b0);
        line_ctrl = 8'h00;
        #1;
        check("R7", "dl_access clear", dl_access, 0);
    endtask

    task automatic t_midframe;
        run_frame("R8", 8'h03, 8'hC3, 1'b1, 8'h3C, 1'b0);
        run_frame("R8", 8'h0C, 8'h12, 1'b1, 8'h03, 1'b0);
    endtask

    initial begin
        rst       = 1'b1;
        line_ctrl = 8'h00;
        tx_data   = 8'h00;
        tx_valid  = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_widths();
        t_parity();
        t_stops();
        t_break();
        t_dl_flag();
        t_midframe();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule